// File: doc/BRIEF.md
# Packed-Pixel FIFO Video Serializer

This block sits between a pixel producer and a video output. The producer writes 16-bit words into a 256-entry buffer. Each word holds several pixels packed into power-of-two fields. On the display side, the block turns those words into one pixel per clock on a narrow colour bus. It schedules its own buffer reads from the blanking flags and the low bits of the horizontal pixel count, which both come from an external timing generator. During blanking the colour bus is held at zero.

The fill level the producer sees is raised early, while eight free slots still remain. This gives a producer with a pipeline time to stop. A one-cycle frame-end strobe empties the buffer, so every frame starts clean.

Top module: `pxser_top`

## Requirements
- R1: A pixel of width PIX_W occupies a field of F bits, where F is the smallest power of two not less than PIX_W. The first pixel of a word sits in bits F-1..0, with the pixel in the low PIX_W bits of that field. The next pixel sits one field higher. With the default PIX_W=3, F=4: pixel k of a word is bits 4k+2..4k, and bit 4k+3 is never shown.
- R2: A buffer read is issued in a cycle where both blanking inputs are low and the horizontal count is a multiple of 16/F (every 4 counts by default). No read is issued in any other cycle.
- R3: The pixel for the count presented in cycle N appears on rgb_o after the third rising edge that follows, that is, during cycle N+3. Each clock after a load, the held word moves down by one field.
- R4: If either blanking input was high in cycle N, rgb_o is all zeros during cycle N+3.
- R5: buf_full_o is high exactly when at least 248 words are stored, and low when fewer are stored.
- R6: When all 256 entries are occupied, a write is discarded. The discarded word never reaches rgb_o.
- R7: A frame_end_i pulse empties the buffer and clears buf_full_o. Words stored before it are never shown.
- R8: A read while the buffer is empty loads nothing. The held word keeps shifting, so once it is used up rgb_o shows zeros.
- R9: After reset, rgb_o is zero and buf_full_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Asynchronous reset, active high |
| px_word_i | input | 16 | Word of packed pixels from the producer |
| px_wr_i | input | 1 | Write strobe for px_word_i |
| buf_full_o | output | 1 | Buffer nearly full (248 or more words) |
| frame_end_i | input | 1 | One-cycle strobe that empties the buffer |
| hblank_i | input | 1 | Horizontal blanking flag |
| vblank_i | input | 1 | Vertical blanking flag |
| hcount_i | input | HCNT_W | Horizontal pixel count |
| rgb_o | output | PIX_W | Pixel bits for the colour converters |

## Verification
The embedded properties check these rules on every cycle:
- A discarded write at full occupancy moves neither the level nor the write pointer.
- The frame-end flush leaves the buffer empty with the flag low.
- A read from an empty buffer yields no valid word.
- A loaded word lands in the shift register intact.
- Blanked slots give zeros.
- No read is issued during blanking.

Only the directed scenarios can show the following, because they need the contents of whole words traced from the producer to the colour bus:
- The field ordering inside a word and the three-cycle latency.
- The read cadence when the active region starts off the 4-count grid.
- The exact level at which the flag trips.
- That overflow words never appear on the output.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

    localparam int WORD_W = 16;

    // smallest power of two not below the pixel width
    function automatic int field_width(input int pix_w);
        int f;
        f = 1;
        while (f < pix_w) f = f * 2;
        return f;
    endfunction

endpackage

// File: rtl/pxser_fifo.sv
module pxser_fifo #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 256,
    parameter int HI_BITS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic              flush_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              full_o
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int LVL_W  = ADDR_W + 1;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [LVL_W-1:0]  level;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        st_d   = st_q;
        do_wr  = wr_i && (st_q.level != TOP_LVL) && !flush_i;
        do_rd  = rd_i && (st_q.level != '0) && !flush_i;
        st_d.rvalid = do_rd;
        if (do_rd) begin
            st_d.rdata = mem_q[st_q.rptr];
            st_d.rptr  = st_q.rptr + 1'b1;
        end
        if (do_wr) st_d.wptr = st_q.wptr + 1'b1;
        if (do_wr && !do_rd)      st_d.level = st_q.level + 1'b1;
        else if (do_rd && !do_wr) st_d.level = st_q.level - 1'b1;
        if (flush_i) begin
            st_d.wptr   = '0;
            st_d.rptr   = '0;
            st_d.level  = '0;
            st_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[st_q.wptr] <= wdata_i;
    end

    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;
    assign full_o   = st_q.level[ADDR_W] | (&st_q.level[ADDR_W-1 -: HI_BITS]);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.level == TOP_LVL && wr_i && !rd_i && !flush_i)
        |=> (st_q.level == TOP_LVL && $stable(st_q.wptr)));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (st_q.level == '0 && !full_o));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && st_q.level == '0) |=> !rvalid_o);

endmodule

// File: rtl/pxser_sched.sv
module pxser_sched #(
    parameter int FIELD_W = 4,
    parameter int WORD_W  = 16,
    parameter int HCNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hblank_i,
    input  logic              vblank_i,
    input  logic [HCNT_W-1:0] hcount_i,
    output logic              active_o,
    output logic              rd_o
);
    localparam int PIX_PER_WORD = WORD_W / FIELD_W;
    localparam logic [HCNT_W-1:0] RD_MASK = HCNT_W'(PIX_PER_WORD - 1);

    logic on_grid;

    always_comb begin
        active_o = !hblank_i && !vblank_i;
        on_grid  = (hcount_i & RD_MASK) == '0;
        rd_o     = active_o && on_grid;
    end

    // R2
    no_blank_read_chk: assert property (@(posedge clk) disable iff (rst)
        (hblank_i || vblank_i) |-> !rd_o);

endmodule

// File: rtl/pxser_shift.sv
module pxser_shift #(
    parameter int PIX_W   = 3,
    parameter int FIELD_W = 4,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              active_i,
    output logic [PIX_W-1:0]  rgb_o
);
    typedef struct packed {
        logic [WORD_W-1:0] pix;
        logic [1:0]        act;
        logic [PIX_W-1:0]  rgb;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.act = {st_q.act[0], active_i};
        st_d.rgb = st_q.act[1] ? st_q.pix[PIX_W-1:0] : '0;
        if (load_i) st_d.pix = word_i;
        else        st_d.pix = st_q.pix >> FIELD_W;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rgb_o = st_q.rgb;

    // R4
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.act[1] |=> (rgb_o == '0));

    // R3
    word_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (st_q.pix == $past(word_i)));

endmodule

// File: rtl/pxser_top.sv
module pxser_top #(
    parameter int PIX_W  = 3,
    parameter int DEPTH  = 256,
    parameter int HCNT_W = 11
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [pxser_pkg::WORD_W-1:0] px_word_i,
    input  logic                        px_wr_i,
    output logic                        buf_full_o,
    input  logic                        frame_end_i,
    input  logic                        hblank_i,
    input  logic                        vblank_i,
    input  logic [HCNT_W-1:0]           hcount_i,
    output logic [PIX_W-1:0]            rgb_o
);
    localparam int WORD_W  = pxser_pkg::WORD_W;
    localparam int FIELD_W = pxser_pkg::field_width(PIX_W);

    logic              rd_req, active;
    logic [WORD_W-1:0] rd_word;
    logic              rd_valid;

    pxser_sched #(.FIELD_W(FIELD_W), .WORD_W(WORD_W), .HCNT_W(HCNT_W)) i_sched (
        .clk(clk), .rst(rst), .hblank_i(hblank_i), .vblank_i(vblank_i),
        .hcount_i(hcount_i), .active_o(active), .rd_o(rd_req)
    );

    pxser_fifo #(.DATA_W(WORD_W), .DEPTH(DEPTH), .HI_BITS(5)) i_fifo (
        .clk(clk), .rst(rst), .wr_i(px_wr_i), .wdata_i(px_word_i),
        .rd_i(rd_req), .flush_i(frame_end_i), .rdata_o(rd_word),
        .rvalid_o(rd_valid), .full_o(buf_full_o)
    );

    pxser_shift #(.PIX_W(PIX_W), .FIELD_W(FIELD_W), .WORD_W(WORD_W)) i_shift (
        .clk(clk), .rst(rst), .load_i(rd_valid), .word_i(rd_word),
        .active_i(active), .rgb_o(rgb_o)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rgb_o == '0));

endmodule

// File: tb/test_pxser_top.sv
module test_pxser_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] px_word = '0;
    logic        px_wr = 1'b0;
    logic        buf_full;
    logic        frame_end = 1'b0;
    logic        hblank = 1'b1;
    logic        vblank = 1'b0;
    logic [10:0] hcount = '0;
    logic [2:0]  rgb;

    int total = 0;
    int bad = 0;
    logic [15:0] q[$];

    always #2 clk = ~clk;

    pxser_top i_pxser_top (
        .clk(clk), .rst(rst), .px_word_i(px_word), .px_wr_i(px_wr),
        .buf_full_o(buf_full), .frame_end_i(frame_end), .hblank_i(hblank),
        .vblank_i(vblank), .hcount_i(hcount), .rgb_o(rgb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        @(negedge clk);
        px_wr = 1'b1;
        px_word = w;
        @(negedge clk);
        px_wr = 1'b0;
        if (q.size() < 256) q.push_back(w);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hblank = 1'b1;
            vblank = 1'b0;
        end
    endtask

    // runs counts start..start+n-1; hblank over [hb_lo,hb_hi) of the run, vblank all if vb
    task automatic stream(input string req, input int start, input int n,
                          input int hb_lo, input int hb_hi, input bit vb);
        logic [2:0]  e[$];
        logic [15:0] s;
        bit act;
        int cnt;
        idle(6);
        s = '0;
        for (int c = 0; c < n + 3; c++) begin
            @(negedge clk);
            if (c >= 3) chk(req, rgb, e[c-3]);
            if (c < n) begin
                cnt = start + c;
                act = !vb && !(c >= hb_lo && c < hb_hi);
                hcount = 11'(cnt);
                hblank = !(c >= hb_lo && c < hb_hi) ? 1'b0 : 1'b1;
                vblank = vb;
                if (act && (cnt % 4 == 0) && q.size() > 0) s = q.pop_front();
                else s = s >> 4;
                e.push_back(act ? s[2:0] : 3'd0);
            end else begin
                hblank = 1'b1;
                vblank = 1'b0;
            end
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 rgb", rgb, 0);
        chk("R9 full", buf_full, 0);
    endtask

    task automatic t_basic;
        // fields 3 and 7: bit 3 of each field set to prove it is dropped (R1)
        push(16'hFA9C);
        push(16'h8E1B);
        push(16'h2D75);
        stream("R1/R3/R8 basic", 0, 20, 99, 99, 1'b0);
    endtask

    task automatic t_offset;
        push(16'h369C);
        push(16'hC5A3);
        stream("R2 offset start", 2, 14, 99, 99, 1'b0);
    endtask

    task automatic t_blank;
        push(16'h7654);
        push(16'hBA98);
        push(16'h3210);
        stream("R4 hblank gap", 0, 16, 3, 6, 1'b0);
        push(16'h1357);
        stream("R4 vblank", 0, 8, 99, 99, 1'b1);
        chk("R2 no read in vblank", q.size(), 1);
        stream("R2 after vblank", 0, 8, 99, 99, 1'b0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 247; i++) push(16'(i * 16'h9E37 + 16'h0101));
        chk("R5 below 248", buf_full, 0);
        push(16'hABCD);
        chk("R5 at 248", buf_full, 1);
        for (int i = 0; i < 8; i++) push(16'(i * 16'h3141 + 16'h0777));
        chk("R5 at 256", buf_full, 1);
        for (int i = 0; i < 4; i++) push(16'hEEEE);
        chk("R6 queue model 256", q.size(), 256);
        stream("R6 drain", 0, 1040, 99, 99, 1'b0);
        chk("R5 empty after drain", buf_full, 0);
    endtask

    task automatic t_flush;
        for (int i = 0; i < 250; i++) push(16'(i * 16'h1F3D + 16'h4321));
        chk("R5 full before flush", buf_full, 1);
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        q.delete();
        chk("R7 full cleared", buf_full, 0);
        stream("R7 flushed words hidden", 0, 12, 99, 99, 1'b0);
        push(16'h5555);
        stream("R7 refill after flush", 0, 8, 99, 99, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_offset();
        t_blank();
        t_full();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule